// File: doc/BRIEF.md
# Horizontal Sync Presence Discriminator

This block decides whether a horizontal sync stream is present. A sync level input is watched for rising edges, and a strobe marks the end of each line period. At every strobe the block sorts the line that just ended into one of three kinds:

- **Clean:** it held at least one pulse and stayed under the noise limit.
- **Empty:** it held no pulse.
- **Noisy:** its pulse count reached the noise limit.

A run of clean lines raises the status output. A run of empty lines lowers it. A single noisy line lowers it at once.

The two run lengths can be set independently, so the decision has hysteresis. The loss run is usually long, so that a few dropped pulses do not flip the status. The acquire run is short, or can be switched into a long range. The noise limit catches video that has lost its sync structure and shows many edges per line. A line-timing generator drives the strobe, and the status goes to whatever logic must know whether a usable signal exists.

Top module: `sync_presence_det`

## Requirements
- R1: After a synchronous active-low reset, `sync_present` is 0. It stays 0 while reset is held, and the reset clears any partial run of lines.
- R2: With `gain_range`=0, the absent-to-present run length is set by `gain_sel`: 0 means one clean line, 1 means 4, 2 means 8 and 3 means 16. The status rises on the strobe that completes that many consecutive clean lines.
- R3: With `gain_range`=1, the absent-to-present run length is 32, 64, 128 or 256 for `gain_sel` 0 to 3.
- R4: The present-to-absent run length is set by `loss_sel`: 1 means 32 consecutive empty lines, 2 means 64, 3 means 128 and 4 means 256. The status falls on the strobe that completes the run.
- R5: When `loss_sel` is 0, or one of the unused codes 5 to 7, empty lines never clear the status.
- R6: When `noise_sel` is from 1 to 7, the noise limit is 4, 8, 16, 32, 64, 128 or 256 pulses respectively. A line whose pulse count is greater than or equal to the limit forces the status to 0 at its strobe, whatever the status was. The same line also clears both runs.
- R7: When `noise_sel` is 0, lines are never judged noisy, however many pulses they hold.
- R8: Any line of a different kind ends the current run. A run that has been broken must start again from one.
- R9: `sync_present` changes only in the cycle after a `line_tick` strobe.
- R10: Each rising edge of `sync_in` counts as one pulse, however long the level stays high. A rising edge seen in the strobe cycle belongs to the line that is ending. The pulse count restarts after every strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Sync level; each rising edge is one pulse |
| line_tick | input | 1 | One-cycle strobe that closes a line period |
| gain_sel | input | 2 | Absent-to-present run length code |
| gain_range | input | 1 | Selects the long range for the acquire run |
| loss_sel | input | 3 | Present-to-absent run length code |
| noise_sel | input | 3 | Pulses-per-line noise limit code |
| sync_present | output | 1 | High while sync is judged present |

## Verification
The assertions assume three things about the inputs:

- `line_tick` is a single-cycle strobe.
- `sync_in` is a clean digital level with at least one low cycle between pulses.
- The configuration fields are steady during a line.

The stimulus keeps to all three. Each pulse is two cycles high followed by two cycles low, or ten cycles high in the width test. The strobe lasts exactly one cycle and is driven with `sync_in` low, except in the test that deliberately places an edge in the strobe cycle. Configuration changes only while reset is held or between lines.

// File: rtl/sdp_pkg.sv
// Package: field decoders for the sync presence discriminator.
// Assumes the select field widths below are fixed by the encoding.
package sdp_pkg;

    localparam int GAIN_SEL_W  = 2;
    localparam int LOSS_SEL_W  = 3;
    localparam int NOISE_SEL_W = 3;

    // Absent-to-present run length in lines; never 0.
    function automatic int unsigned gain_lines(input logic [GAIN_SEL_W-1:0] sel,
                                               input logic rng);
        if (rng)
            return 32 << sel;
        else if (sel == '0)
            return 1;
        else
            return 2 << sel;
    endfunction

    // Present-to-absent run length in lines; 0 means the path is off.
    function automatic int unsigned loss_lines(input logic [LOSS_SEL_W-1:0] sel);
        if (sel >= 1 && sel <= 4)
            return 16 << sel;
        else
            return 0;
    endfunction

    // Pulses-per-line noise limit; 0 means the filter is off.
    function automatic int unsigned noise_limit(input logic [NOISE_SEL_W-1:0] sel);
        if (sel == '0)
            return 0;
        else
            return 2 << sel;
    endfunction

endpackage

// File: rtl/sdp_pulse_counter.sv
// Module: per-line pulse counter and line classifier.
// Counts rising edges of the sync level between line strobes, saturating
// at all-ones. In the strobe cycle it reports whether the ending line held
// any pulse and whether its count reached the noise limit. An edge in the
// strobe cycle is folded into the ending line.
// Assumes line_tick is a one-cycle strobe and sync_lvl is clock-synchronous.
module sdp_pulse_counter #(
    parameter int PULSE_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_lvl,
    input  logic               line_tick,
    input  logic [PULSE_W-1:0] noise_thr,
    input  logic               noise_en,
    output logic               line_seen,
    output logic               line_noisy
);
    localparam logic [PULSE_W-1:0] CNT_MAX = '1;

    logic               sync_q;
    logic               rise;
    logic [PULSE_W-1:0] cnt;
    logic [PULSE_W:0]   total;

    assign rise  = sync_lvl & ~sync_q;
    assign total = {1'b0, cnt} + (PULSE_W+1)'(rise);

    // Line classification, valid in the strobe cycle.
    always_comb begin
        line_seen  = (total != '0);
        line_noisy = noise_en && (total >= {1'b0, noise_thr});
    end

    // Previous sync level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_lvl;
    end

    // Saturating edge count, restarted by every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (line_tick)
            cnt <= '0;
        else if (rise && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // R10: a full count never wraps inside a line.
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !line_tick) |=> (cnt == CNT_MAX));

    // R10: a level that stays high adds nothing after its first edge.
    a_r10_level_once: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && sync_lvl && !line_tick) |=> $stable(cnt));

endmodule

// File: rtl/sdp_run_tracker.sv
// Module: consecutive-line run counters and the presence status flag.
// Counts consecutive clean lines toward acquisition and consecutive empty
// lines toward loss. A noisy line clears both runs and the status at once.
// The status moves only on a strobe.
// Assumes gain_need is at least 1 and fits in RUN_W bits.
module sdp_run_tracker #(
    parameter int RUN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             line_seen,
    input  logic             line_noisy,
    input  logic [RUN_W-1:0] gain_need,
    input  logic [RUN_W-1:0] loss_need,
    input  logic             loss_en,
    output logic             present
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] hit_run;
    logic [RUN_W-1:0] miss_run;
    logic [RUN_W-1:0] hit_nx;
    logic [RUN_W-1:0] miss_nx;

    // Saturating next values of both runs.
    always_comb begin
        hit_nx  = (hit_run  == RUN_MAX) ? hit_run  : hit_run  + 1'b1;
        miss_nx = (miss_run == RUN_MAX) ? miss_run : miss_run + 1'b1;
    end

    // Run bookkeeping and the status decision at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_run  <= '0;
            miss_run <= '0;
            present  <= 1'b0;
        end else if (line_tick) begin
            if (line_noisy) begin
                hit_run  <= '0;
                miss_run <= '0;
                present  <= 1'b0;
            end else if (line_seen) begin
                miss_run <= '0;
                if (!present && hit_nx >= gain_need) begin
                    present <= 1'b1;
                    hit_run <= '0;
                end else begin
                    hit_run <= hit_nx;
                end
            end else begin
                hit_run <= '0;
                if (present && loss_en && miss_nx >= loss_need) begin
                    present  <= 1'b0;
                    miss_run <= '0;
                end else begin
                    miss_run <= miss_nx;
                end
            end
        end
    end

    // R9: the status holds between strobes.
    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(present));

    // R6: a noisy line always leaves the status low.
    a_r6_noise_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_noisy) |=> !present);

    // R2: a rise follows a clean line.
    a_r2_rise_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> $past(line_tick && line_seen && !line_noisy));

    // R4: a fall follows a noisy line or an empty line with loss enabled.
    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present) |-> $past(line_tick && (line_noisy || (!line_seen && loss_en))));

    // R5: with loss disabled, only noise can clear the status.
    a_r5_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        (present && line_tick && !line_noisy && !loss_en) |=> present);

endmodule

// File: rtl/sync_presence_det.sv
// Module: top of the sync presence discriminator.
// Decodes the configuration fields into run lengths and a noise limit,
// optionally resynchronises the sync level, and joins the pulse counter
// to the run tracker.
// Assumes the configuration fields are steady during a line. With
// SYNC_STAGES > 0, pulses are delayed by that many cycles relative to
// line_tick.
module sync_presence_det
    import sdp_pkg::*;
#(
    parameter int RUN_W       = 9,
    parameter int PULSE_W     = 9,
    parameter int SYNC_STAGES = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_in,
    input  logic                   line_tick,
    input  logic [GAIN_SEL_W-1:0]  gain_sel,
    input  logic                   gain_range,
    input  logic [LOSS_SEL_W-1:0]  loss_sel,
    input  logic [NOISE_SEL_W-1:0] noise_sel,
    output logic                   sync_present
);
    logic               sync_lvl;
    logic [RUN_W-1:0]   gain_need;
    logic [RUN_W-1:0]   loss_need;
    logic               loss_en;
    logic [PULSE_W-1:0] noise_thr;
    logic               noise_en;
    logic               line_seen;
    logic               line_noisy;

    // Optional resynchronising stages on the sync level.
    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign sync_lvl = sync_in;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] stg;
            // Shift the sync level through the stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[SYNC_STAGES-2:0], sync_in};
            end
            assign sync_lvl = stg[SYNC_STAGES-1];
        end
    endgenerate

    // Field decoding.
    always_comb begin
        gain_need = RUN_W'(gain_lines(gain_sel, gain_range));
        loss_need = RUN_W'(loss_lines(loss_sel));
        loss_en   = (loss_lines(loss_sel) != 0);
        noise_thr = PULSE_W'(noise_limit(noise_sel));
        noise_en  = (noise_limit(noise_sel) != 0);
    end

    sdp_pulse_counter #(.PULSE_W(PULSE_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl   (sync_lvl),
        .line_tick  (line_tick),
        .noise_thr  (noise_thr),
        .noise_en   (noise_en),
        .line_seen  (line_seen),
        .line_noisy (line_noisy)
    );

    sdp_run_tracker #(.RUN_W(RUN_W)) u_runs (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .line_seen  (line_seen),
        .line_noisy (line_noisy),
        .gain_need  (gain_need),
        .loss_need  (loss_need),
        .loss_en    (loss_en),
        .present    (sync_present)
    );

    // R1: reset leaves the status low on the following cycle.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !sync_present);

endmodule

// File: tb/tb_sync_presence_det.sv
// Bench: a vector table walked by one loop, then directed tests.
module tb_sync_presence_det;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       line_tick = 1'b0;
    logic [1:0] gain_sel = '0;
    logic       gain_range = 1'b0;
    logic [2:0] loss_sel = '0;
    logic [2:0] noise_sel = '0;
    logic       sync_present;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    sync_presence_det dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_in      (sync_in),
        .line_tick    (line_tick),
        .gain_sel     (gain_sel),
        .gain_range   (gain_range),
        .loss_sel     (loss_sel),
        .noise_sel    (noise_sel),
        .sync_present (sync_present)
    );

    typedef struct packed {
        logic [1:0] gsel;
        logic       grng;
        logic [2:0] lsel;
        logic [2:0] nsel;
        logic       pre;     // one clean line first (acquire with gsel 0)
        logic [9:0] lines;
        logic [9:0] pulses;
        logic       exp_b;   // status after lines-1 lines
        logic       exp_a;   // status after all lines
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 3'd0, 3'd0, 1'b0, 10'd4,   10'd1,   1'b0, 1'b1, 4'd2}, // R2 4 lines
        '{2'd2, 1'b0, 3'd0, 3'd0, 1'b0, 10'd8,   10'd1,   1'b0, 1'b1, 4'd2}, // R2 8 lines
        '{2'd3, 1'b0, 3'd0, 3'd0, 1'b0, 10'd16,  10'd1,   1'b0, 1'b1, 4'd2}, // R2 16 lines
        '{2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 10'd1,   10'd1,   1'b0, 1'b1, 4'd2}, // R2 one line
        '{2'd0, 1'b1, 3'd0, 3'd0, 1'b0, 10'd32,  10'd1,   1'b0, 1'b1, 4'd3}, // R3 32
        '{2'd1, 1'b1, 3'd0, 3'd0, 1'b0, 10'd64,  10'd2,   1'b0, 1'b1, 4'd3}, // R3 64
        '{2'd3, 1'b1, 3'd0, 3'd0, 1'b0, 10'd256, 10'd1,   1'b0, 1'b1, 4'd3}, // R3 256
        '{2'd0, 1'b0, 3'd1, 3'd0, 1'b1, 10'd32,  10'd0,   1'b1, 1'b0, 4'd4}, // R4 32
        '{2'd0, 1'b0, 3'd2, 3'd0, 1'b1, 10'd64,  10'd0,   1'b1, 1'b0, 4'd4}, // R4 64
        '{2'd0, 1'b0, 3'd4, 3'd0, 1'b1, 10'd256, 10'd0,   1'b1, 1'b0, 4'd4}, // R4 256
        '{2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 10'd300, 10'd0,   1'b1, 1'b1, 4'd5}, // R5 code 0
        '{2'd0, 1'b0, 3'd5, 3'd0, 1'b1, 10'd300, 10'd0,   1'b1, 1'b1, 4'd5}, // R5 code 5
        '{2'd0, 1'b0, 3'd0, 3'd1, 1'b1, 10'd1,   10'd4,   1'b1, 1'b0, 4'd6}, // R6 4 of 4
        '{2'd0, 1'b0, 3'd0, 3'd1, 1'b1, 10'd1,   10'd3,   1'b1, 1'b1, 4'd6}, // R6 3 of 4
        '{2'd0, 1'b0, 3'd0, 3'd7, 1'b1, 10'd1,   10'd256, 1'b1, 1'b0, 4'd6}, // R6 256 of 256
        '{2'd0, 1'b0, 3'd0, 3'd7, 1'b1, 10'd1,   10'd255, 1'b1, 1'b1, 4'd6}, // R6 255 of 256
        '{2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 10'd1,   10'd300, 1'b1, 1'b1, 4'd7}, // R7 no limit
        '{2'd1, 1'b0, 3'd0, 3'd2, 1'b0, 10'd4,   10'd8,   1'b0, 1'b0, 4'd6}  // R6 noisy never acquires
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: sync_present=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One line: p pulses of width w high / 2 low, a gap, then a strobe.
    // With at_tick set, an extra edge rises in the strobe cycle.
    task automatic line(input int p, input int w = 2, input bit at_tick = 1'b0);
        for (int k = 0; k < p; k++) begin
            sync_in = 1'b1;
            repeat (w) @(negedge clk);
            sync_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        @(negedge clk);
        line_tick = 1'b1;
        if (at_tick) sync_in = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        sync_in   = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            summary();
        end
    end

    initial begin
        // R1: the status is low in reset and stays low while reset is held.
        repeat (2) @(negedge clk);
        check(sync_present, 1'b0, "R1 in reset");
        line(1);
        line(1);
        check(sync_present, 1'b0, "R1 strobes ignored in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(sync_present, 1'b0, "R1 after release");

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            gain_sel   = VECS[v].gsel;
            gain_range = VECS[v].grng;
            loss_sel   = VECS[v].lsel;
            noise_sel  = VECS[v].nsel;
            do_reset();
            if (VECS[v].pre) line(1);
            for (int i = 0; i < int'(VECS[v].lines) - 1; i++) line(int'(VECS[v].pulses));
            check(sync_present, VECS[v].exp_b, $sformatf("R%0d vector %0d before", VECS[v].req, v));
            line(int'(VECS[v].pulses));
            check(sync_present, VECS[v].exp_a, $sformatf("R%0d vector %0d after", VECS[v].req, v));
        end

        // R1: reset clears a partial acquire run.
        gain_sel = 2'd1; gain_range = 1'b0; loss_sel = 3'd0; noise_sel = 3'd0;
        do_reset();
        repeat (3) line(1);
        do_reset();
        line(1);
        check(sync_present, 1'b0, "R1 partial run cleared");
        repeat (3) line(1);
        check(sync_present, 1'b1, "R1 full run after reset");

        // R8: an empty line breaks the acquire run.
        do_reset();
        repeat (3) line(1);
        line(0);
        repeat (3) line(1);
        check(sync_present, 1'b0, "R8 acquire run broken");
        line(1);
        check(sync_present, 1'b1, "R8 acquire run restarted");

        // R8: a clean line breaks the loss run.
        gain_sel = 2'd0; loss_sel = 3'd1;
        do_reset();
        line(1);
        repeat (31) line(0);
        line(1);
        repeat (31) line(0);
        check(sync_present, 1'b1, "R8 loss run broken");
        line(0);
        check(sync_present, 1'b0, "R8 loss run restarted");

        // R9: a pulse without a strobe leaves the status unchanged.
        do_reset();
        sync_in = 1'b1;
        repeat (2) @(negedge clk);
        sync_in = 1'b0;
        repeat (6) @(negedge clk);
        check(sync_present, 1'b0, "R9 no strobe no change");
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        check(sync_present, 1'b1, "R9 strobe commits");

        // R10: long pulses count once each.
        loss_sel = 3'd0; noise_sel = 3'd1;
        do_reset();
        line(1);
        line(3, 10);
        check(sync_present, 1'b1, "R10 wide pulses count once");

        // R10: an edge in the strobe cycle belongs to the ending line.
        line(3, 2, 1'b1);
        check(sync_present, 1'b0, "R10 edge at strobe counted");

        // R10: the count restarts after each strobe.
        noise_sel = 3'd0;
        do_reset();
        line(0, 2, 1'b1);
        check(sync_present, 1'b1, "R10 strobe-cycle edge makes line clean");
        noise_sel = 3'd1;
        line(3);
        line(3);
        check(sync_present, 1'b1, "R10 count restarts per line");

        summary();
    end

endmodule